// File: doc/BRIEF.md
# Flash Command Interface

This block sits behind the pins of a byte-wide flash memory. It decodes two-cycle bus commands and runs the operations they select. The host drives active-low chip-enable, output-enable and write-enable strobes, an address bus and an 8-bit data bus. The strobes are sampled on the block clock. The first write cycle chooses an operation. The following write or read cycle carries it out. A small register-based cell array of `2**ADDR_W` bytes stands in for the memory core.

The block returns array data, the two identifier bytes, verify data for erase or program, or auto-erase status. For status, only data bit 7 is driven. The auto-erase sequencer first forces every byte to 00h one byte per clock. It then waits `ERASE_CYC` clocks and sets the whole array to FFh. Both durations are clock counts, not physical times.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the command mode is read and every cell holds FFh. A read cycle returns the cell at `addr` with all eight output enables set.
- R2: After a write of 90h, read cycles return 07h when `addr[0]` is 0 and 19h when `addr[0]` is 1.
- R3: A write of 40h followed by a write of address A and data D replaces cell A with (old AND D), so bits can only be cleared. The mode then returns to read.
- R4: A write of 20h followed by a second 20h sets every cell to FFh. 20h followed by any other value changes no cell.
- R5: A write of A0h at address A selects cell A. Later read cycles return that cell whatever the bus address is.
- R6: A write of C0h makes read cycles return the cell at the address of the most recent program operation.
- R7: A write of 30h followed by a second 30h starts auto-erase and enters status mode. Status reads set only output enable bit 7. Bit 7 reads 0 for exactly `2**ADDR_W + ERASE_CYC` clocks after the committing edge, then reads 1. At that point every cell is FFh.
- R8: While auto-erase runs, bus writes are ignored. Status mode is still in force when the erase finishes.
- R9: A setup code (30h or FFh) followed by a second write that differs from it performs no operation and returns to read mode.
- R10: Outputs are enabled only while `ce_n` and `oe_n` are low and `we_n` is high. In a setup mode that is waiting for its second write, no output is enabled.
- R11: The write address is the one present when `we_n` falls. The write data is the value present when `we_n` rises. Strobes given while `ce_n` is high have no effect.
- R12: A first-cycle code outside the command set selects read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data bus |
| dout_en | output | 8 | Per-bit output drive enable; a 0 bit means high impedance |

## Verification
The bench builds the block with `ADDR_W = 4` and `ERASE_CYC = 6`, which gives 16 cells and a 22-clock auto-erase. At that size every address can be read, identified, programmed and erase-verified in each sweep. An independent byte model tracks the AND-only program rule. The short erase lets the bench count the exact number of busy status clocks, and lets it issue writes inside the busy window to show they are ignored.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [3:0] {
    M_READ,
    M_IDENT,
    M_ERS_SETUP,
    M_ERS_VERIFY,
    M_AUTO_SETUP,
    M_STATUS,
    M_PRG_SETUP,
    M_PRG_VERIFY,
    M_RST_SETUP
  } fci_mode_e;

  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERS_VFY   = 8'hA0;
  localparam logic [7:0] OP_AUTO      = 8'h30;
  localparam logic [7:0] OP_PROGRAM   = 8'h40;
  localparam logic [7:0] OP_PRG_VFY   = 8'hC0;
  localparam logic [7:0] OP_RESET     = 8'hFF;

  localparam logic [7:0] ID_MAKER     = 8'h07;
  localparam logic [7:0] ID_DEVICE    = 8'h19;

endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_stb
);

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_fall;

  assign we_fall = ~ce_n & we_q & ~we_n;
  assign wr_stb  = ~ce_n & ~we_q & we_n;
  assign wr_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
    end else begin
      we_q <= we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (we_fall) begin
      addr_q <= addr;
    end
  end

endmodule

// File: rtl/fci_cmd_decoder.sv
module fci_cmd_decoder
  import fci_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output fci_mode_e         mode,
  output logic [ADDR_W-1:0] vfy_addr,
  output logic [ADDR_W-1:0] prg_addr,
  output logic              prog_go,
  output logic              chip_clear,
  output logic              auto_go
);

  fci_mode_e         mode_q, mode_d;
  logic [ADDR_W-1:0] vfy_q, vfy_d;
  logic [ADDR_W-1:0] prg_q, prg_d;
  logic              accept;

  assign accept = wr_stb & ~busy;

  always_comb begin
    mode_d     = mode_q;
    vfy_d      = vfy_q;
    prg_d      = prg_q;
    prog_go    = 1'b0;
    chip_clear = 1'b0;
    auto_go    = 1'b0;
    if (accept) begin
      case (mode_q)
        M_ERS_SETUP: begin
          chip_clear = (wr_data == OP_ERASE);
          mode_d     = M_READ;
        end
        M_AUTO_SETUP: begin
          if (wr_data == OP_AUTO) begin
            auto_go = 1'b1;
            mode_d  = M_STATUS;
          end else begin
            mode_d  = M_READ;
          end
        end
        M_PRG_SETUP: begin
          prog_go = 1'b1;
          prg_d   = wr_addr;
          mode_d  = M_READ;
        end
        M_RST_SETUP: begin
          mode_d = M_READ;
        end
        default: begin
          case (wr_data)
            OP_READ:    mode_d = M_READ;
            OP_IDENT:   mode_d = M_IDENT;
            OP_ERASE:   mode_d = M_ERS_SETUP;
            OP_ERS_VFY: begin
              mode_d = M_ERS_VERIFY;
              vfy_d  = wr_addr;
            end
            OP_AUTO:    mode_d = M_AUTO_SETUP;
            OP_PROGRAM: mode_d = M_PRG_SETUP;
            OP_PRG_VFY: mode_d = M_PRG_VERIFY;
            OP_RESET:   mode_d = M_RST_SETUP;
            default:    mode_d = M_READ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ;
      vfy_q  <= '0;
      prg_q  <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
      vfy_q  <= vfy_d;
      prg_q  <= prg_d;
    end
  end

  assign mode     = mode_q;
  assign vfy_addr = vfy_q;
  assign prg_addr = prg_q;

endmodule

// File: rtl/fci_erase_seq.sv
module fci_erase_seq #(
  parameter int ADDR_W    = 5,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_idx,
  output logic              clear_all
);

  localparam int                CNT_W = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
  localparam logic [ADDR_W-1:0] IDX_LAST = '1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ERASE_CYC - 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_WAIT} sq_e;

  sq_e               st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    fill_we   = 1'b0;
    clear_all = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_FILL;
          idx_d = '0;
        end
      end
      SQ_FILL: begin
        fill_we = 1'b1;
        if (idx_q == IDX_LAST) begin
          st_d  = SQ_WAIT;
          cnt_d = '0;
        end else begin
          idx_d = idx_q + ADDR_W'(1);
        end
      end
      SQ_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          st_d      = SQ_IDLE;
          clear_all = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign fill_idx = idx_q;

endmodule

// File: rtl/fci_cell_array.sv
module fci_cell_array #(
  parameter int ADDR_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prog_we,
  input  logic [ADDR_W-1:0]              prog_addr,
  input  logic [7:0]                     prog_data,
  input  logic                           fill_we,
  input  logic [ADDR_W-1:0]              fill_idx,
  input  logic                           clear_all,
  output logic [(1<<ADDR_W)-1:0][7:0]    cells
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][7:0] cells_q, cells_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells_d[g] =
      clear_all                                   ? 8'hFF :
      (fill_we && (fill_idx == ADDR_W'(g)))       ? 8'h00 :
      (prog_we && (prog_addr == ADDR_W'(g)))      ? (cells_q[g] & prog_data) :
                                                    cells_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '1;
    end else begin
      cells_q <= cells_d;
    end
  end

  assign cells = cells_q;

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic [7:0]        dout_en
);

  localparam int DEPTH = 1 << ADDR_W;

  logic                  wr_stb;
  logic [ADDR_W-1:0]     wr_addr;
  fci_mode_e             mode;
  logic [ADDR_W-1:0]     vfy_addr;
  logic [ADDR_W-1:0]     prg_addr;
  logic                  prog_go;
  logic                  chip_clear;
  logic                  auto_go;
  logic                  busy;
  logic                  fill_we;
  logic [ADDR_W-1:0]     fill_idx;
  logic                  auto_clear;
  logic [DEPTH-1:0][7:0] cells;
  logic                  rd_ok;

  fci_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (addr),
    .wr_addr (wr_addr),
    .wr_stb  (wr_stb)
  );

  fci_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (din),
    .busy       (busy),
    .mode       (mode),
    .vfy_addr   (vfy_addr),
    .prg_addr   (prg_addr),
    .prog_go    (prog_go),
    .chip_clear (chip_clear),
    .auto_go    (auto_go)
  );

  fci_erase_seq #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (auto_go),
    .busy      (busy),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .clear_all (auto_clear)
  );

  fci_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_go),
    .prog_addr (wr_addr),
    .prog_data (din),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .clear_all (auto_clear | chip_clear),
    .cells     (cells)
  );

  assign rd_ok = ~ce_n & ~oe_n & we_n;

  always_comb begin
    dout    = 8'h00;
    dout_en = 8'h00;
    if (rd_ok) begin
      case (mode)
        M_READ: begin
          dout    = cells[addr];
          dout_en = 8'hFF;
        end
        M_IDENT: begin
          dout    = addr[0] ? ID_DEVICE : ID_MAKER;
          dout_en = 8'hFF;
        end
        M_ERS_VERIFY: begin
          dout    = cells[vfy_addr];
          dout_en = 8'hFF;
        end
        M_PRG_VERIFY: begin
          dout    = cells[prg_addr];
          dout_en = 8'hFF;
        end
        M_STATUS: begin
          dout    = {~busy, 7'b0};
          dout_en = 8'h80;
        end
        default: begin
          dout    = 8'h00;
          dout_en = 8'h00;
        end
      endcase
    end
  end

endmodule

// File: rtl/fci_chk.sv
module fci_chk
  import fci_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ce_n,
  input logic                        oe_n,
  input logic                        we_n,
  input logic [7:0]                  dout,
  input logic [7:0]                  dout_en,
  input fci_mode_e                   mode,
  input logic                        busy,
  input logic                        wr_stb,
  input logic                        auto_go,
  input logic                        chip_clear,
  input logic [(1<<ADDR_W)-1:0][7:0] cells
);

  // R10
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dout_en == 8'h00));

  // R7
  stat_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STATUS && dout_en != 8'h00) |-> (dout_en == 8'h80));

  // R7
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == M_STATUS && dout_en[7]) |-> !dout[7]);

  // R7
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_go |=> busy);

  // R7
  auto_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&cells));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> $stable(mode));

  // R4
  chip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_clear |=> (&cells));

endmodule

bind flash_cmd_if fci_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .dout       (dout),
  .dout_en    (dout_en),
  .mode       (mode),
  .busy       (busy),
  .wr_stb     (wr_stb),
  .auto_go    (auto_go),
  .chip_clear (chip_clear),
  .cells      (cells)
);

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int ECYC  = 6;

  logic          clk;
  logic          rst_n;
  logic          ce_n;
  logic          oe_n;
  logic          we_n;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic [7:0]    dout_en;

  int total;
  int bad;
  int cyc;
  logic [7:0] model [DEPTH];

  flash_cmd_if #(.ADDR_W(AW), .ERASE_CYC(ECYC)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Address valid at the falling strobe, then scrambled; data scrambled
  // until just before the rising strobe (R11 on every write).
  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = a; din = ~d;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); addr = ~a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; din = 8'h5A;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d,
                          output logic [7:0] en);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1; d = dout; en = dout_en;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic sweep_array(input string req);
    logic [7:0] d, en;
    for (int a = 0; a < DEPTH; a++) begin
      bus_read(AW'(a), d, en);
      check8(req, d, model[a]);
      check8(req, en, 8'hFF);
    end
  endtask

  task automatic wait_done(output logic [7:0] en, output logic [7:0] d);
    int n;
    n = 0;
    en = 8'h00;
    d = 8'h00;
    while (n < 1000) begin
      bus_read('0, d, en);
      if (d[7]) break;
      n++;
    end
  endtask

  initial begin
    logic [7:0] d, en;
    int lows;
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = 8'h00;
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state reads erased cells
    sweep_array("R1");

    // R10: output-enable high drives nothing
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 4'd3; #1;
    check8("R10", dout_en, 8'h00);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; #1;
    check8("R10", dout_en, 8'h00);
    @(negedge clk); oe_n = 1'b1;

    // R2: identifier codes at every address
    bus_write('0, 8'h90);
    for (int a = 0; a < DEPTH; a++) begin
      bus_read(AW'(a), d, en);
      check8("R2", d, (a % 2 == 1) ? 8'h19 : 8'h07);
    end

    // R12: unknown code returns to read mode
    bus_write('0, 8'h55);
    bus_read(4'd3, d, en);
    check8("R12", d, 8'hFF);
    check8("R12", en, 8'hFF);

    // R3: program every cell, then a second AND pass on even cells
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] p;
      p = 8'((a * 37 + 11) ^ 8'hC3);
      bus_write('0, 8'h40);
      bus_write(AW'(a), p);
      model[a] = model[a] & p;
    end
    for (int a = 0; a < DEPTH; a += 2) begin
      logic [7:0] p;
      p = 8'((a * 91) ^ 8'h7E);
      bus_write('0, 8'h40);
      bus_write(AW'(a), p);
      model[a] = model[a] & p;
    end
    sweep_array("R3");

    // R6: program verify returns the last programmed cell (address 14)
    bus_write('0, 8'hC0);
    bus_read(4'd1, d, en);
    check8("R6", d, model[14]);
    bus_read(4'd7, d, en);
    check8("R6", d, model[14]);

    // R10: setup mode waiting for its second cycle drives nothing
    bus_write('0, 8'h40);
    bus_read(4'd2, d, en);
    check8("R10", en, 8'h00);
    bus_write(4'd2, 8'hFF);
    model[2] = model[2] & 8'hFF;

    // R5: erase verify selects the cell named in the command write
    for (int a = 0; a < DEPTH; a++) begin
      bus_write(AW'(a), 8'hA0);
      bus_read(AW'(DEPTH - 1 - a), d, en);
      check8("R5", d, model[a]);
    end

    // R9: mismatched second cycles perform nothing
    bus_write('0, 8'h30);
    bus_write('0, 8'h31);
    bus_write('0, 8'hFF);
    bus_write('0, 8'h00);
    // R4: 20h followed by other value changes nothing
    bus_write('0, 8'h20);
    bus_write('0, 8'h21);
    sweep_array("R9");

    // R11: strobes with chip enable high are ignored
    @(negedge clk); ce_n = 1'b1; addr = '0; din = 8'h90;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    bus_read(4'd0, d, en);
    check8("R11", d, model[0]);

    // R4: chip erase
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep_array("R4");

    // R7: auto-erase, exact busy length and status lane
    for (int a = 0; a < DEPTH; a += 3) begin
      bus_write('0, 8'h40);
      bus_write(AW'(a), 8'h0F);
    end
    bus_write('0, 8'h30);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = '0; din = 8'hCF;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); din = 8'h30;
    @(negedge clk); we_n = 1'b1;
    lows = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); oe_n = 1'b0; din = 8'h00; #1;
      if (k == 0) check8("R7", dout_en, 8'h80);
      if (dout[7]) break;
      lows++;
    end
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    total++;
    if (lows != DEPTH + ECYC) begin
      bad++;
      $display("FAIL R7: actual busy=%0d expected=%0d", lows, DEPTH + ECYC);
    end
    bus_read(4'd5, d, en);
    check8("R7", en, 8'h80);
    check8("R7", d, 8'h80);
    bus_write('0, 8'h00);
    sweep_array("R7");

    // R8: writes during auto-erase are ignored
    bus_write('0, 8'h40);
    bus_write(4'd6, 8'h00);
    model[6] = 8'h00;
    bus_write('0, 8'h30);
    bus_write('0, 8'h30);
    bus_write('0, 8'h00);
    bus_write('0, 8'h90);
    wait_done(en, d);
    check8("R8", en, 8'h80);
    check8("R8", d, 8'h80);
    bus_write('0, 8'h00);
    model[6] = 8'hFF;
    bus_read(4'd6, d, en);
    check8("R8", d, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule